// File: doc/BRIEF.md
# DS3 Path Data Link Transmit Interface

This block supplies the path maintenance data link bits that a DS3 transmitter places into the three data link slots of every M-frame. A strobe from the framer marks each slot. For every strobe the block presents one new bit on `dl_bit`, and that bit holds until the next strobe. A configuration bit picks where the bits come from.

In external mode the block drives a gapped data link clock on a shared output pin. It pulls the clock low after each slot strobe for a programmable number of overhead clock cycles and then lets it rise. It captures the serial bit that the outside source returns and hands that bit to the inserter at the following slot. In internal mode a host writes bytes into a one-byte holding register. From there the bytes move into a shift register, which sends them least significant bit first. When a byte moves from the holding register into the shift register, the shared pin becomes a refill interrupt. Its polarity is selectable: active-low open drain or active-high. When no data is left, the block sends ones and sets a sticky underrun flag.

Top module: `dlink_tx_if`

## Requirements
- R1: With the source-select bit (config bit 0) at 1, `dl_pin_oe` is 1 and `dl_pin_val` carries the data link clock, which idles high.
- R2: In external mode a slot strobe makes the data link clock fall on the next falling overhead clock edge. The clock stays low for exactly `LOW_CYC` overhead clock cycles and then rises on a falling edge, so each strobe gives one clock cycle.
- R3: The external serial input is captured on the first rising overhead edge after the data link clock rises. It appears on `dl_bit` after the next slot strobe. The captured value is 1 after reset.
- R4: In internal mode each slot strobe moves `dl_bit` to the next bit of the current byte, least significant bit first. The update comes on the clock edge that samples the strobe.
- R5: The refill interrupt becomes active on the edge where a byte moves from the holding register into the shift register. That is the strobe that sends the byte's first bit. A byte that is only written does not raise it.
- R6: Any register write clears the interrupt: a write to the data register (address 1) or a write to the config register (address 0).
- R7: Config bit 1 sets the interrupt polarity. At 0 the pin is active-low open drain: `dl_pin_oe` equals the interrupt and `dl_pin_val` is 0. At 1 it is active-high: `dl_pin_oe` is 1 and `dl_pin_val` equals the interrupt.
- R8: A slot strobe in internal mode that finds both the shift and holding registers empty sends a 1 and sets `urun_flag`. The flag stays set until a config write with bit 3 set.
- R9: A byte written while the shift register is busy follows the previous byte with no gap. No idle bit and no underrun come between them.
- R10: After reset the block is in internal mode with active-low polarity, the interrupt is inactive, `dl_pin_oe` is 0, `dl_bit` is 1 and `urun_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Overhead clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_stb | input | 1 | One-cycle strobe per data link bit slot |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | 0 = config, 1 = transmit data |
| wr_data | input | DW | Write data |
| ext_ser_in | input | 1 | Serial bit returned by the external source |
| dl_bit | output | 1 | Data link bit for the current slot |
| dl_pin_val | output | 1 | Shared pin value (clock or interrupt) |
| dl_pin_oe | output | 1 | Shared pin drive enable |
| urun_flag | output | 1 | Sticky underrun status |

## Verification
The `dl_bit` output, the interrupt and the underrun flag all change on the same rising edge that samples a strobe or a write. The bench drives each stimulus for one cycle starting at a falling edge and reads the results at the next falling edge. The data link clock is retimed on falling edges and is due half a cycle after the strobe edge. The bench therefore reads it shortly after each falling edge and counts exactly `LOW_CYC` low samples before it expects the high sample. The external bit is due one full slot after it is sampled, so the bench holds the input steady for a whole slot and checks the value only after the following strobe.

// File: rtl/dlink_pkg.sv
// Shared constants and types for the DS3 data link transmit interface.
// Assumes a one-bit register address: config and transmit data only.
package dlink_pkg;
    localparam int unsigned ADDR_W = 1;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 1'b1;

    // Config bit positions (software-visible encoding)
    localparam int unsigned CFG_EXT_BIT   = 0;
    localparam int unsigned CFG_HI_BIT    = 1;
    localparam int unsigned CFG_URCLR_BIT = 3;

    typedef struct packed {
        logic act_high;
        logic ext_sel;
    } dl_cfg_t;
endpackage

// File: rtl/dlink_regs.sv
// Register write decode: holds the config bits and turns writes into pulses.
// Assumes DW > CFG_URCLR_BIT so all config bits fit in one write word.
module dlink_regs
    import dlink_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output dl_cfg_t           cfg_o,
    output logic              data_wr_o,
    output logic              any_wr_o,
    output logic              urun_clr_o,
    output logic [DW-1:0]     byte_o
);
    dl_cfg_t cfg_q;
    logic    cfg_wr;

    // Decode one-cycle write pulses
    always_comb begin
        cfg_wr     = wr_en && (wr_addr == ADDR_CFG);
        data_wr_o  = wr_en && (wr_addr == ADDR_DATA);
        any_wr_o   = wr_en;
        urun_clr_o = cfg_wr && wr_data[CFG_URCLR_BIT];
        byte_o     = wr_data;
    end

    // Config register, reset to internal source with active-low interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.ext_sel  <= wr_data[CFG_EXT_BIT];
            cfg_q.act_high <= wr_data[CFG_HI_BIT];
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/dlink_clkgen.sv
// External-source path: gapped data link clock and serial bit capture.
// Each enabled strobe starts a low phase of LOW_CYC overhead cycles. The pin
// level is retimed on the falling overhead edge. The serial input is taken on
// the first rising edge after the clock rises and goes out at the next strobe.
module dlink_clkgen #(
    parameter int unsigned LOW_CYC = 85
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  logic ser_in,
    output logic dl_clk_o,
    output logic req_o,
    output logic bit_o
);
    localparam int unsigned CNT_W = $clog2(LOW_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             smp_pend_q;
    logic             cap_q;
    logic             bit_q;
    logic             dl_clk_q;

    // Low-phase counter, sample scheduling and slot bit hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            req_q      <= 1'b1;
            smp_pend_q <= 1'b0;
            cap_q      <= 1'b1;
            bit_q      <= 1'b1;
        end else begin
            smp_pend_q <= 1'b0;
            if (en && stb) begin
                cnt_q <= CNT_W'(LOW_CYC);
                req_q <= 1'b0;
                bit_q <= cap_q;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    req_q      <= 1'b1;
                    smp_pend_q <= 1'b1;
                end
            end
            if (smp_pend_q) begin
                cap_q <= ser_in;
            end
        end
    end

    // Retime the clock level onto the falling overhead edge
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            dl_clk_q <= 1'b1;
        end else begin
            dl_clk_q <= req_q;
        end
    end

    assign dl_clk_o = dl_clk_q;
    assign req_o    = req_q;
    assign bit_o    = bit_q;
endmodule

// File: rtl/dlink_byte_tx.sv
// Internal-source path: holding register, LSB-first shift register, refill
// interrupt and sticky underrun. Bytes move to the shift register only at the
// strobe that needs their first bit, so the host has a full byte time to
// refill the holding register.
module dlink_byte_tx #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          stb,
    input  logic          data_wr,
    input  logic          any_wr,
    input  logic          urun_clr,
    input  logic [DW-1:0] wr_byte,
    output logic          bit_o,
    output logic          irq_o,
    output logic          urun_o,
    output logic          load_o
);
    localparam int unsigned BCW = $clog2(DW + 1);

    logic [DW-1:0]  hold_q;
    logic           hold_full_q;
    logic [DW-1:0]  sh_q;
    logic [BCW-1:0] left_q;
    logic           bit_q;
    logic           irq_q;
    logic           urun_q;
    logic           do_shift;
    logic           do_load;
    logic           do_starve;

    // Classify the current strobe
    always_comb begin
        do_shift  = en && stb && (left_q != '0);
        do_load   = en && stb && (left_q == '0) && hold_full_q;
        do_starve = en && stb && (left_q == '0) && !hold_full_q;
    end

    // Shift register and slot bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            bit_q  <= 1'b1;
        end else if (do_shift) begin
            bit_q  <= sh_q[0];
            sh_q   <= sh_q >> 1;
            left_q <= left_q - 1'b1;
        end else if (do_load) begin
            bit_q  <= hold_q[0];
            sh_q   <= hold_q >> 1;
            left_q <= BCW'(DW - 1);
        end else if (do_starve) begin
            bit_q  <= 1'b1;
        end
    end

    // Holding register fill and drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (data_wr) begin
            hold_q      <= wr_byte;
            hold_full_q <= 1'b1;
        end else if (do_load) begin
            hold_full_q <= 1'b0;
        end
    end

    // Refill interrupt: set on load, any host write clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (any_wr) begin
            irq_q <= 1'b0;
        end else if (do_load) begin
            irq_q <= 1'b1;
        end
    end

    // Sticky underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_q <= 1'b0;
        end else if (do_starve) begin
            urun_q <= 1'b1;
        end else if (urun_clr) begin
            urun_q <= 1'b0;
        end
    end

    assign bit_o  = bit_q;
    assign irq_o  = irq_q;
    assign urun_o = urun_q;
    assign load_o = do_load;
endmodule

// File: rtl/dlink_tx_if.sv
// Top of the DS3 data link transmit interface. Selects the bit source and
// drives the shared pin as either the gapped data link clock or the refill
// interrupt with programmable polarity. Assumes slot_stb is a one-cycle pulse
// with at least LOW_CYC+2 cycles between pulses.
module dlink_tx_if
    import dlink_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned LOW_CYC = 85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_stb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              ext_ser_in,
    output logic              dl_bit,
    output logic              dl_pin_val,
    output logic              dl_pin_oe,
    output logic              urun_flag
);
    dl_cfg_t       cfg_w;
    logic          data_wr_w;
    logic          any_wr_w;
    logic          urun_clr_w;
    logic [DW-1:0] byte_w;
    logic          ext_sel_w;
    logic          act_high_w;
    logic          dl_clk_w;
    logic          clk_req_w;
    logic          ext_bit_w;
    logic          int_bit_w;
    logic          irq_w;
    logic          urun_w;
    logic          int_load_w;

    dlink_regs #(.DW(DW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cfg_o      (cfg_w),
        .data_wr_o  (data_wr_w),
        .any_wr_o   (any_wr_w),
        .urun_clr_o (urun_clr_w),
        .byte_o     (byte_w)
    );

    assign ext_sel_w  = cfg_w.ext_sel;
    assign act_high_w = cfg_w.act_high;

    dlink_clkgen #(.LOW_CYC(LOW_CYC)) clkgen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ext_sel_w),
        .stb      (slot_stb),
        .ser_in   (ext_ser_in),
        .dl_clk_o (dl_clk_w),
        .req_o    (clk_req_w),
        .bit_o    (ext_bit_w)
    );

    dlink_byte_tx #(.DW(DW)) byte_tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (!ext_sel_w),
        .stb      (slot_stb),
        .data_wr  (data_wr_w),
        .any_wr   (any_wr_w),
        .urun_clr (urun_clr_w),
        .wr_byte  (byte_w),
        .bit_o    (int_bit_w),
        .irq_o    (irq_w),
        .urun_o   (urun_w),
        .load_o   (int_load_w)
    );

    // Source select and shared pin drive
    always_comb begin
        dl_bit = ext_sel_w ? ext_bit_w : int_bit_w;
        if (ext_sel_w) begin
            dl_pin_oe  = 1'b1;
            dl_pin_val = dl_clk_w;
        end else if (act_high_w) begin
            dl_pin_oe  = 1'b1;
            dl_pin_val = irq_w;
        end else begin
            dl_pin_oe  = irq_w;
            dl_pin_val = 1'b0;
        end
    end

    assign urun_flag = urun_w;
endmodule

// File: rtl/dlink_tx_chk.sv
// Assertion checker for dlink_tx_if, attached by bind below.
module dlink_tx_chk #(
    parameter int unsigned LOW_CYC = 85
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic ext_sel,
    input logic act_high,
    input logic clk_req,
    input logic int_load,
    input logic irq,
    input logic urun,
    input logic urun_clr,
    input logic pin_val,
    input logic pin_oe
);
    localparam int unsigned LW = $clog2(LOW_CYC + 2);
    logic [LW-1:0] low_cnt;

    // Count cycles the clock request has been low, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || clk_req) begin
            low_cnt <= '0;
        end else if (low_cnt != LW'(LOW_CYC + 1)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r2_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_req) |-> (low_cnt >= LW'(LOW_CYC)));

    a_r1_ext_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> pin_oe);

    a_r5_irq_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(int_load));

    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !irq);

    a_r7_low_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && !act_high) |-> !pin_val);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !urun_clr) |=> urun);
endmodule

bind dlink_tx_if dlink_tx_chk #(.LOW_CYC(LOW_CYC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ext_sel  (ext_sel_w),
    .act_high (act_high_w),
    .clk_req  (clk_req_w),
    .int_load (int_load_w),
    .irq      (irq_w),
    .urun     (urun_w),
    .urun_clr (urun_clr_w),
    .pin_val  (dl_pin_val),
    .pin_oe   (dl_pin_oe)
);

// File: tb/dlink_tx_if_tb_top.sv
`timescale 1ns/1ps
module dlink_tx_if_tb_top;
    localparam int unsigned DW  = 8;
    localparam int unsigned LOW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot_stb = 1'b0;
    logic          wr_en = 1'b0;
    logic [0:0]    wr_addr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          ext_ser_in = 1'b0;
    logic          dl_bit;
    logic          dl_pin_val;
    logic          dl_pin_oe;
    logic          urun_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    dlink_tx_if #(.DW(DW), .LOW_CYC(LOW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_stb   (slot_stb),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_ser_in (ext_ser_in),
        .dl_bit     (dl_bit),
        .dl_pin_val (dl_pin_val),
        .dl_pin_oe  (dl_pin_oe),
        .urun_flag  (urun_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) slot_stb = 1'b1;
        @(negedge clk) slot_stb = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 oe", dl_pin_oe, 1'b0);
        chk("R10 val", dl_pin_val, 1'b0);
        chk("R10 bit", dl_bit, 1'b1);
        chk("R10 urun", urun_flag, 1'b0);
    endtask

    task automatic t_underrun();
        strobe();
        chk("R8 idle one", dl_bit, 1'b1);
        chk("R8 urun set", urun_flag, 1'b1);
        idle(3);
        chk("R8 urun sticky", urun_flag, 1'b1);
        wr(1'b0, 8'h08);
        chk("R8 urun cleared", urun_flag, 1'b0);
    endtask

    task automatic t_bytes();
        logic [7:0] a = 8'hA5;
        logic [7:0] b = 8'h3C;
        wr(1'b1, a);
        chk("R5 no irq on write", dl_pin_oe, 1'b0);
        strobe();
        chk("R4 bit0", dl_bit, a[0]);
        chk("R5 irq on load", dl_pin_oe, 1'b1);
        chk("R7 low pol value", dl_pin_val, 1'b0);
        wr(1'b1, b);
        chk("R6 data write clears", dl_pin_oe, 1'b0);
        for (int i = 1; i < 8; i++) begin
            strobe();
            chk("R4 lsb first", dl_bit, a[i]);
        end
        strobe();
        chk("R9 no gap", dl_bit, b[0]);
        chk("R9 no underrun", urun_flag, 1'b0);
        chk("R5 irq second load", dl_pin_oe, 1'b1);
        for (int i = 1; i < 8; i++) begin
            strobe();
            chk("R4 second byte", dl_bit, b[i]);
        end
        wr(1'b0, 8'h00);
        chk("R6 config write clears", dl_pin_oe, 1'b0);
        strobe();
        chk("R8 idle after end", dl_bit, 1'b1);
        chk("R8 urun after end", urun_flag, 1'b1);
        wr(1'b0, 8'h08);
    endtask

    task automatic t_polarity();
        wr(1'b0, 8'h02);
        chk("R7 high pol oe", dl_pin_oe, 1'b1);
        chk("R7 high pol idle", dl_pin_val, 1'b0);
        wr(1'b1, 8'h01);
        strobe();
        chk("R7 high pol active", dl_pin_val, 1'b1);
        chk("R4 bit", dl_bit, 1'b1);
        wr(1'b0, 8'h02);
        chk("R6 high pol clear", dl_pin_val, 1'b0);
    endtask

    task automatic t_ext();
        wr(1'b0, 8'h01);
        chk("R1 ext oe", dl_pin_oe, 1'b1);
        chk("R1 clk idle high", dl_pin_val, 1'b1);
        ext_ser_in = 1'b0;
        strobe();
        #1;
        chk("R2 clk low", dl_pin_val, 1'b0);
        chk("R3 reset capture", dl_bit, 1'b1);
        for (int i = 1; i < int'(LOW); i++) begin
            @(negedge clk); #1;
            chk("R2 low width", dl_pin_val, 1'b0);
        end
        @(negedge clk); #1;
        chk("R2 clk rises", dl_pin_val, 1'b1);
        idle(3);
        ext_ser_in = 1'b1;
        strobe();
        chk("R3 captured zero", dl_bit, 1'b0);
        idle(LOW + 4);
        ext_ser_in = 1'b0;
        strobe();
        chk("R3 captured one", dl_bit, 1'b1);
        chk("R1 oe with irq off", dl_pin_oe, 1'b1);
        idle(LOW + 4);
    endtask

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_underrun();
        t_bytes();
        t_polarity();
        t_ext();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule